// File: doc/BRIEF.md
# Debug Port Run-Control Unit

This unit sits between an external debugger and a processor core. The debugger issues single-beat transactions. Each transaction carries a two-bit region, an address, a write flag and write data, and the unit returns one word of read data a cycle after it accepts the transaction.

Region 0 reaches the control and status registers. Region 1 reaches the integer registers, the program-counter pair, a stack-trace count and a read-only stack-trace buffer. Region 2 is a control window. The register contents themselves live in the core, so the unit forwards those accesses over a narrow architectural-state port.

The unit owns the run state of the core: normal, halted or stepping. In stepping mode it compares a retired-step counter against a target and halts on its own when the target is reached. It also owns a one-shot fetch override: a debugger-supplied instruction word replaces the memory fetch once, when the fetch PC equals a programmed address.

Top module: `dbg_run_ctrl`

## Requirements
- R1: `req_ready_o` is high whenever no response is pending. A transaction accepted at a clock edge gives `rsp_valid_o` high for exactly the following cycle, and `req_ready_o` is low during that cycle.
- R2: Region 0, and region 1 at addresses below NREGS (32), are forwarded on the state port in the accepting cycle. The space code is 0 for region 0 and 1 for integer registers, and the port carries the same address, write flag and data. The response carries `arch_rdata_i` as sampled then, which is the old value on a write.
- R3: In region 1, address NREGS returns the current PC and ignores writes. Address NREGS+1 is the next-PC and address NREGS+2 is the stack-trace count. Both are writable, and a write returns the old value.
- R4: Region 1 addresses from 128 to 128+TRACE_DEPTH-1 read the trace buffer over the state port, with space code 2, index addr-128 and `arch_we_o` held low. Other unmapped region 1 addresses, all of region 3, and control addresses 5, 6 and anything above 8 read 0, and writes to them have no effect.
- R5: A write to control address 0 acts on bit 0 first and bit 1 second. If bit 0 (halt) is set, the core halts. Otherwise, if bit 1 (step) is set, the core enters stepping. Otherwise the core enters normal running.
- R6: A read of control address 0 returns the halt status in bit 0, the breakpoint status in bit 1, a core id of 0 in bits 15:8, and zero in every other bit.
- R7: Control address 1 (step count), address 4 (breakpoint control) and address 7 (inject address) are read/write. Addresses 2 and 3 both return the step counter. Address 8 returns the injected word.
- R8: Entering stepping sets the target to the step counter plus the step count. While stepping, a counter at or above the target forces the halted state. The counter increments on `advance_i` only when the core is not halted and is not being forced to halt in that cycle.
- R9: Each counted advance moves the next-PC into the PC and loads `advance_npc_i` into the next-PC. A debugger write to the next-PC in the same cycle takes priority.
- R10: A write to control address 8 stores the word, arms the injection and clears the breakpoint status. A `brk_hit_i` pulse sets the breakpoint status.
- R11: While the injection is armed and `fetch_pc_o` equals the inject address, a fetch returns the injected word with `mem_req_o` low, and the arm flag clears. Otherwise `mem_req_o` follows `fetch_req_i` and the fetch returns `mem_rdata_i`.
- R12: Reset (active-low, asynchronous) sets the PC and next-PC to RESET_VEC (0x1000). It clears the step counter, the step count, the breakpoint control, the breakpoint status and the inject flag, and it leaves the core running normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Debug transaction valid |
| req_ready_o | output | 1 | Transaction accepted when high with valid |
| req_region_i | input | 2 | Region select |
| req_addr_i | input | AW | Address within region |
| req_write_i | input | 1 | Write flag |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | DW | Response data |
| arch_valid_o | output | 1 | State-port access strobe |
| arch_space_o | output | 2 | 0 CSR, 1 integer register, 2 trace buffer |
| arch_addr_o | output | AW | State-port index |
| arch_we_o | output | 1 | State-port write |
| arch_wdata_o | output | DW | State-port write data |
| arch_rdata_i | input | DW | State-port read data, combinational |
| advance_i | input | 1 | Core requests one step |
| advance_npc_i | input | DW | Next-PC produced by that step |
| brk_hit_i | input | 1 | Breakpoint hit, sets status |
| halted_o | output | 1 | Core is halted |
| fetch_pc_o | output | DW | Current PC used for fetch |
| fetch_req_i | input | 1 | Core fetch request |
| mem_req_o | output | 1 | Memory fetch request |
| mem_rdata_i | input | IW | Memory fetch data |
| fetch_instr_o | output | IW | Instruction delivered to core |

## Verification
The bench drives a step count through stepping mode with `advance_i` held high. It checks that exactly that many steps are counted before the halt; a unit with an off-by-one compare would overshoot or stop one short. It writes the halt and step bits together to confirm that halt wins, and it checks that a halted core does not count advances. It tries the fetch override first at a non-matching PC, where the arm must survive, and then at the matching PC, where exactly one fetch must be replaced. It writes to the PC slot, the trace buffer and unmapped control addresses to show that a unit that decodes them wrongly would corrupt state.

// File: rtl/dbg_rc_pkg.sv
package dbg_rc_pkg;
  typedef enum logic [1:0] {
    RS_RUN  = 2'd0,
    RS_HALT = 2'd1,
    RS_STEP = 2'd2
  } run_state_e;

  localparam logic [1:0] RGN_CSR  = 2'd0;
  localparam logic [1:0] RGN_CORE = 2'd1;
  localparam logic [1:0] RGN_CTRL = 2'd2;

  localparam logic [1:0] SPC_CSR   = 2'd0;
  localparam logic [1:0] SPC_GPR   = 2'd1;
  localparam logic [1:0] SPC_TRACE = 2'd2;

  localparam int CA_CTRL  = 0;
  localparam int CA_STEPS = 1;
  localparam int CA_CNT0  = 2;
  localparam int CA_CNT1  = 3;
  localparam int CA_BRK   = 4;
  localparam int CA_INJA  = 7;
  localparam int CA_INJW  = 8;
endpackage

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
  import dbg_rc_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_i,
  input  logic          cmd_halt_i,
  input  logic          cmd_step_i,
  input  logic [CW-1:0] step_num_i,
  input  logic          advance_i,
  output run_state_e    state_o,
  output logic [CW-1:0] cnt_o,
  output logic          adv_ok_o
);
  run_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, tgt_q;
  logic          reach;

  assign reach    = (st_q == RS_STEP) && (cnt_q >= tgt_q);
  assign adv_ok_o = advance_i && (st_q != RS_HALT) && !reach;
  assign state_o  = st_q;
  assign cnt_o    = cnt_q;

  always_comb begin
    st_d = st_q;
    if (cmd_i) begin
      if (cmd_halt_i)      st_d = RS_HALT;
      else if (cmd_step_i) st_d = RS_STEP;
      else                 st_d = RS_RUN;
    end else if (reach) begin
      st_d = RS_HALT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RS_RUN;
      cnt_q <= '0;
      tgt_q <= '0;
    end else begin
      st_q <= st_d;
      if (adv_ok_o) cnt_q <= cnt_q + 1'b1;
      if (cmd_i && !cmd_halt_i && cmd_step_i) tgt_q <= cnt_q + step_num_i;
    end
  end

  // R8
  a_r8_halt_freezes_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RS_HALT) |=> $stable(cnt_q));
  a_r8_target_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reach && !cmd_i) |=> (st_q == RS_HALT));
  // R5
  a_r5_halt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && cmd_halt_i) |=> (st_q == RS_HALT));
endmodule

// File: rtl/dbg_fetch_inject.sv
module dbg_fetch_inject #(
  parameter int PW = 64,
  parameter int IW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          fetch_req_i,
  input  logic [PW-1:0] pc_i,
  input  logic [PW-1:0] inj_addr_i,
  input  logic [IW-1:0] inj_word_i,
  input  logic [IW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic [IW-1:0] instr_o
);
  logic armed_q, hit;

  assign hit       = armed_q && (pc_i == inj_addr_i);
  assign mem_req_o = fetch_req_i && !hit;
  assign instr_o   = hit ? inj_word_i : mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 armed_q <= 1'b0;
    else if (arm_i)              armed_q <= 1'b1;
    else if (fetch_req_i && hit) armed_q <= 1'b0;
  end

  // R11
  a_r11_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && hit && !arm_i) |=> !armed_q);
  a_r10_arm_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> armed_q);
  a_r11_miss_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !hit) |=> armed_q);
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_rc_pkg::*;
#(
  parameter int          DW          = 64,
  parameter int          AW          = 12,
  parameter int          IW          = 32,
  parameter int          NREGS       = 32,
  parameter int          TRACE_BASE  = 128,
  parameter int          TRACE_DEPTH = 8,
  parameter logic [63:0] RESET_VEC   = 64'h1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_region_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          arch_valid_o,
  output logic [1:0]    arch_space_o,
  output logic [AW-1:0] arch_addr_o,
  output logic          arch_we_o,
  output logic [DW-1:0] arch_wdata_o,
  input  logic [DW-1:0] arch_rdata_i,
  input  logic          advance_i,
  input  logic [DW-1:0] advance_npc_i,
  input  logic          brk_hit_i,
  output logic          halted_o,
  output logic [DW-1:0] fetch_pc_o,
  input  logic          fetch_req_i,
  output logic          mem_req_o,
  input  logic [IW-1:0] mem_rdata_i,
  output logic [IW-1:0] fetch_instr_o
);
  localparam logic [AW-1:0] A_PC     = AW'(NREGS);
  localparam logic [AW-1:0] A_NPC    = AW'(NREGS + 1);
  localparam logic [AW-1:0] A_TCNT   = AW'(NREGS + 2);
  localparam logic [AW-1:0] A_TB_LO  = AW'(TRACE_BASE);
  localparam logic [AW-1:0] A_TB_HI  = AW'(TRACE_BASE + TRACE_DEPTH);

  logic          rsp_q;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [DW-1:0] pc_q, npc_q, tcnt_q, steps_q, brk_q, inja_q;
  logic [IW-1:0] injw_q;
  logic          bp_q;
  logic          acc, wr;
  logic          wr_npc, wr_tcnt, wr_steps, wr_brk, wr_inja, wr_injw, cmd;
  logic [DW-1:0] status, cnt;
  run_state_e    state;
  logic          adv_ok;

  assign req_ready_o = !rsp_q;
  assign acc         = req_valid_i && req_ready_o;
  assign wr          = acc && req_write_i;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign halted_o    = (state == RS_HALT);
  assign fetch_pc_o  = pc_q;

  always_comb begin
    status     = '0;
    status[0]  = halted_o;
    status[1]  = bp_q;
  end

  always_comb begin
    arch_valid_o = 1'b0;
    arch_space_o = SPC_CSR;
    arch_addr_o  = req_addr_i;
    arch_we_o    = 1'b0;
    arch_wdata_o = req_wdata_i;
    rdata_d      = '0;
    wr_npc = 1'b0; wr_tcnt = 1'b0; wr_steps = 1'b0; wr_brk = 1'b0;
    wr_inja = 1'b0; wr_injw = 1'b0; cmd = 1'b0;
    unique case (req_region_i)
      RGN_CSR: begin
        arch_valid_o = acc;
        arch_we_o    = wr;
        rdata_d      = arch_rdata_i;
      end
      RGN_CORE: begin
        if (req_addr_i < A_PC) begin
          arch_valid_o = acc;
          arch_space_o = SPC_GPR;
          arch_we_o    = wr;
          rdata_d      = arch_rdata_i;
        end else if (req_addr_i == A_PC) begin
          rdata_d = pc_q;
        end else if (req_addr_i == A_NPC) begin
          rdata_d = npc_q;
          wr_npc  = wr;
        end else if (req_addr_i == A_TCNT) begin
          rdata_d = tcnt_q;
          wr_tcnt = wr;
        end else if (req_addr_i >= A_TB_LO && req_addr_i < A_TB_HI) begin
          arch_valid_o = acc;
          arch_space_o = SPC_TRACE;
          arch_addr_o  = req_addr_i - A_TB_LO;
          rdata_d      = arch_rdata_i;
        end
      end
      RGN_CTRL: begin
        if (req_addr_i == AW'(CA_CTRL)) begin
          rdata_d = status;
          cmd     = wr;
        end else if (req_addr_i == AW'(CA_STEPS)) begin
          rdata_d  = steps_q;
          wr_steps = wr;
        end else if (req_addr_i == AW'(CA_CNT0) || req_addr_i == AW'(CA_CNT1)) begin
          rdata_d = cnt;
        end else if (req_addr_i == AW'(CA_BRK)) begin
          rdata_d = brk_q;
          wr_brk  = wr;
        end else if (req_addr_i == AW'(CA_INJA)) begin
          rdata_d = inja_q;
          wr_inja = wr;
        end else if (req_addr_i == AW'(CA_INJW)) begin
          rdata_d = DW'(injw_q);
          wr_injw = wr;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
      pc_q    <= DW'(RESET_VEC);
      npc_q   <= DW'(RESET_VEC);
      tcnt_q  <= '0;
      steps_q <= '0;
      brk_q   <= '0;
      inja_q  <= '0;
      injw_q  <= '0;
      bp_q    <= 1'b0;
    end else begin
      rsp_q <= acc;
      if (acc) rdata_q <= rdata_d;
      if (adv_ok) begin
        pc_q  <= npc_q;
        npc_q <= advance_npc_i;
      end
      if (wr_npc)   npc_q   <= req_wdata_i;
      if (wr_tcnt)  tcnt_q  <= req_wdata_i;
      if (wr_steps) steps_q <= req_wdata_i;
      if (wr_brk)   brk_q   <= req_wdata_i;
      if (wr_inja)  inja_q  <= req_wdata_i;
      if (wr_injw)  injw_q  <= req_wdata_i[IW-1:0];
      if (wr_injw)        bp_q <= 1'b0;
      else if (brk_hit_i) bp_q <= 1'b1;
    end
  end

  dbg_run_fsm #(.CW(DW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .cmd_halt_i (req_wdata_i[0]),
    .cmd_step_i (req_wdata_i[1]),
    .step_num_i (steps_q),
    .advance_i  (advance_i),
    .state_o    (state),
    .cnt_o      (cnt),
    .adv_ok_o   (adv_ok)
  );

  dbg_fetch_inject #(.PW(DW), .IW(IW)) u_inj (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (wr_injw),
    .fetch_req_i (fetch_req_i),
    .pc_i        (pc_q),
    .inj_addr_i  (inja_q),
    .inj_word_i  (injw_q),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .instr_o     (fetch_instr_o)
  );

  // R1
  a_r1_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  a_r9_pc_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_ok |=> (pc_q == $past(npc_q)));
  // R4
  a_r4_trace_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arch_valid_o && arch_space_o == SPC_TRACE) |-> !arch_we_o);
  // R3
  a_r3_pc_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_ok |=> $stable(pc_q));
endmodule

// File: tb/dbg_run_ctrl_test.sv
`timescale 1ns/1ps
module dbg_run_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_region = '0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic        arch_valid, arch_we;
  logic [1:0]  arch_space;
  logic [11:0] arch_addr;
  logic [63:0] arch_wdata, arch_rdata;
  logic        advance = 1'b0, brk_hit = 1'b0, fetch_req = 1'b0;
  logic [63:0] advance_npc = '0;
  logic        halted, mem_req;
  logic [63:0] fetch_pc;
  logic [31:0] mem_rdata = 32'h0000_0013, fetch_instr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [63:0] csr_mem [64];
  logic [63:0] gpr_mem [32];
  logic [63:0] trc_mem [8];
  logic [63:0] exp_csr [64];
  logic [63:0] exp_gpr [32];

  // reference state model (R5 R8 R9)
  logic [63:0] m_pc, m_npc, m_cnt, m_tgt, m_steps;
  int          m_state; // 0 run 1 halt 2 step
  bit          m_busy;

  always #2 clk = ~clk;

  dbg_run_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_region_i(req_region),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .arch_valid_o(arch_valid), .arch_space_o(arch_space), .arch_addr_o(arch_addr),
    .arch_we_o(arch_we), .arch_wdata_o(arch_wdata), .arch_rdata_i(arch_rdata),
    .advance_i(advance), .advance_npc_i(advance_npc), .brk_hit_i(brk_hit),
    .halted_o(halted), .fetch_pc_o(fetch_pc), .fetch_req_i(fetch_req),
    .mem_req_o(mem_req), .mem_rdata_i(mem_rdata), .fetch_instr_o(fetch_instr)
  );

  always_comb begin
    case (arch_space)
      2'd0:    arch_rdata = csr_mem[arch_addr[5:0]];
      2'd1:    arch_rdata = gpr_mem[arch_addr[4:0]];
      2'd2:    arch_rdata = trc_mem[arch_addr[2:0]];
      default: arch_rdata = '0;
    endcase
  end

  always @(posedge clk) begin
    if (arch_valid && arch_we) begin
      if (arch_space == 2'd0) csr_mem[arch_addr[5:0]] <= arch_wdata;
      else if (arch_space == 2'd1) gpr_mem[arch_addr[4:0]] <= arch_wdata;
      else if (arch_space == 2'd2) trc_mem[arch_addr[2:0]] <= arch_wdata;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 64'h1000; m_npc = 64'h1000; m_cnt = 0; m_tgt = 0; m_steps = 0;
      m_state = 0; m_busy = 0;
    end else begin
      bit acc, reach, ok;
      acc   = req_valid && !m_busy;
      reach = (m_state == 2) && (m_cnt >= m_tgt);
      ok    = advance && (m_state != 1) && !reach;
      if (acc && req_write && req_region == 2 && req_addr == 0) begin
        if (req_wdata[0]) m_state = 1;
        else if (req_wdata[1]) begin m_state = 2; m_tgt = m_cnt + m_steps; end
        else m_state = 0;
      end else if (reach) m_state = 1;
      if (ok) begin m_cnt = m_cnt + 1; m_pc = m_npc; m_npc = advance_npc; end
      if (acc && req_write && req_region == 1 && req_addr == 33) m_npc = req_wdata;
      if (acc && req_write && req_region == 2 && req_addr == 1) m_steps = req_wdata;
      m_busy = acc;
    end
  end

  function automatic logic [63:0] status_word(bit h, bit bp);
    return {62'b0, bp, h};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] rg, input logic [11:0] ad, input bit we,
                     input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1; req_region = rg; req_addr = ad; req_write = we; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R1 ready low", 64'(req_ready), 64'd0);
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance = 1; advance_npc = {32'h0, $urandom} & 64'hFFFF_FFFC;
    end
    @(negedge clk);
    advance = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, c0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) begin csr_mem[i] = 64'(i) * 64'h101; exp_csr[i] = csr_mem[i]; end
    for (int i = 0; i < 32; i++) begin gpr_mem[i] = 64'(i) << 4; exp_gpr[i] = gpr_mem[i]; end
    for (int i = 0; i < 8; i++)  trc_mem[i] = 64'(i) * 64'h111;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 halted", 64'(halted), 0);
    chk("R12 pc", fetch_pc, 64'h1000);
    chk("R1 ready idle", 64'(req_ready), 1);
    txn(2'd1, 12'd33, 0, 0, rd); chk("R12 npc", rd, 64'h1000);
    txn(2'd2, 12'd2, 0, 0, rd);  chk("R12 count", rd, 0);
    txn(2'd2, 12'd4, 0, 0, rd);  chk("R12 brk ctrl", rd, 0);
    txn(2'd2, 12'd0, 0, 0, rd);  chk("R6 R12 status", rd, status_word(0, 0));
    fetch_req = 1; #1;
    chk("R12 R11 no inject", {31'b0, mem_req, fetch_instr}, {31'b0, 1'b1, mem_rdata});
    fetch_req = 0;

    // R2 R9 random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        int a; bit w; logic [63:0] d;
        a = $urandom_range(0, 63); w = $urandom_range(0, 1); d = {$urandom, $urandom};
        txn(2'd0, 12'(a), w, d, rd);
        chk("R2 csr old value", rd, exp_csr[a]);
        if (w) exp_csr[a] = d;
      end else if (op == 1) begin
        int a; bit w; logic [63:0] d;
        a = $urandom_range(0, 31); w = $urandom_range(0, 1); d = {$urandom, $urandom};
        txn(2'd1, 12'(a), w, d, rd);
        chk("R2 gpr old value", rd, exp_gpr[a]);
        if (w) exp_gpr[a] = d;
      end else if (op == 2) begin
        adv($urandom_range(1, 4));
      end else begin
        txn(2'd2, 12'($urandom_range(2, 3)), 0, 0, rd); chk("R7 R8 count", rd, m_cnt);
        txn(2'd1, 12'd32, 0, 0, rd); chk("R9 pc", rd, m_pc);
        txn(2'd1, 12'd33, 0, 0, rd); chk("R9 npc", rd, m_npc);
      end
    end

    // R3
    c0 = m_pc;
    txn(2'd1, 12'd32, 1, 64'hDEAD, rd); chk("R3 pc write returns pc", rd, c0);
    txn(2'd1, 12'd32, 0, 0, rd);        chk("R3 pc read-only", rd, c0);
    c0 = m_npc;
    txn(2'd1, 12'd33, 1, 64'h2000, rd); chk("R3 npc old", rd, c0);
    txn(2'd1, 12'd33, 0, 0, rd);        chk("R3 npc new", rd, 64'h2000);
    txn(2'd1, 12'd34, 1, 64'd7, rd);    chk("R3 tcnt old", rd, 0);
    txn(2'd1, 12'd34, 0, 0, rd);        chk("R3 tcnt new", rd, 7);

    // R4
    txn(2'd1, 12'd130, 0, 0, rd);       chk("R4 trace read", rd, 64'h222);
    txn(2'd1, 12'd129, 1, 64'h55, rd);
    txn(2'd1, 12'd129, 0, 0, rd);       chk("R4 trace not written", rd, 64'h111);
    txn(2'd1, 12'd100, 1, 64'h9, rd);   chk("R4 unmapped core", rd, 0);
    txn(2'd3, 12'd0, 1, 64'h3, rd);     chk("R4 region3", rd, 0);
    chk("R4 region3 no halt", 64'(halted), 0);

    // R7
    txn(2'd2, 12'd1, 1, 64'd5, rd);     chk("R7 steps old", rd, 0);
    txn(2'd2, 12'd4, 1, 64'hA5, rd);
    txn(2'd2, 12'd4, 0, 0, rd);         chk("R7 brk ctrl", rd, 64'hA5);
    txn(2'd2, 12'd5, 1, 64'h77, rd);    chk("R7 addr5 zero", rd, 0);
    txn(2'd2, 12'd6, 1, 64'h77, rd);    chk("R7 addr6 zero", rd, 0);
    txn(2'd2, 12'd20, 1, 64'h77, rd);   chk("R4 addr20 zero", rd, 0);
    txn(2'd2, 12'd1, 0, 0, rd);         chk("R7 steps kept", rd, 5);
    txn(2'd2, 12'd4, 0, 0, rd);         chk("R7 brk kept", rd, 64'hA5);

    // R5 R8 stepping
    c0 = m_cnt;
    txn(2'd2, 12'd0, 1, 64'h2, rd);
    adv(12);
    chk("R8 step halted", 64'(halted), 1);
    txn(2'd2, 12'd2, 0, 0, rd);         chk("R8 exact steps", rd, c0 + 5);
    txn(2'd2, 12'd0, 0, 0, rd);         chk("R6 status halted", rd, status_word(1, 0));
    txn(2'd2, 12'd0, 1, 64'h0, rd);
    chk("R5 go runs", 64'(halted), 0);
    txn(2'd2, 12'd0, 1, 64'h3, rd);
    chk("R5 halt wins", 64'(halted), 1);
    c0 = m_cnt;
    adv(4);
    txn(2'd2, 12'd3, 0, 0, rd);         chk("R8 halted no count", rd, c0);
    txn(2'd2, 12'd1, 1, 64'd0, rd);
    txn(2'd2, 12'd0, 1, 64'h2, rd);
    @(negedge clk);
    chk("R8 zero steps halts", 64'(halted), 1);
    txn(2'd2, 12'd0, 1, 64'h0, rd);
    chk("R8 model state", 64'(m_state), 0);

    // R10 R11
    @(negedge clk); brk_hit = 1; @(negedge clk); brk_hit = 0;
    txn(2'd2, 12'd0, 0, 0, rd);         chk("R10 bp set", rd, status_word(0, 1));
    txn(2'd2, 12'd7, 1, m_pc + 8, rd);
    txn(2'd2, 12'd8, 1, 64'hCAFE_0073, rd);
    txn(2'd2, 12'd0, 0, 0, rd);         chk("R10 bp cleared", rd, status_word(0, 0));
    txn(2'd2, 12'd8, 0, 0, rd);         chk("R7 inj word", rd, 64'hCAFE_0073);
    @(negedge clk); fetch_req = 1; #1;
    chk("R11 miss uses memory", {31'b0, mem_req, fetch_instr}, {31'b0, 1'b1, mem_rdata});
    @(negedge clk); fetch_req = 0;
    chk("R9 pc stable", fetch_pc, m_pc);
    txn(2'd2, 12'd7, 1, m_pc, rd);
    @(negedge clk); fetch_req = 1; #1;
    chk("R11 hit injects", {31'b0, mem_req, fetch_instr}, {31'b0, 1'b0, 32'hCAFE_0073});
    @(negedge clk); #1;
    chk("R11 one shot", {31'b0, mem_req, fetch_instr}, {31'b0, 1'b1, mem_rdata});
    fetch_req = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule